// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps time of day and a calendar as packed BCD counters that advance once for every pulse on a one-second tick input. The host does not see the counters directly. It sees a second, visible set of registers, reached through a simple synchronous register port with a write strobe, an address, write data and combinational read data.

Two hold bits in the control register decide how the visible copy relates to the counters. While both bits are clear, the visible copy follows the counters. The read hold freezes the visible copy so that a multi-register read returns one consistent instant, and the counters keep running meanwhile. The write hold also freezes the copy and lets the host overwrite it. Releasing the write hold copies the whole visible set into the counters in a single cycle, and counting continues from there.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the counters and the visible copy hold 00:00:00 on day 01, date 01, month 01, year 00, century 00. Both hold bits are 0, and the frequency-test bit (day bit 6) is 0.
- R2: The register map is as follows. Address 0 is control, read as {write hold bit 7, read hold bit 6, century BCD bits 5:0}. Address 1 is seconds, with bit 7 as the oscillator stop bit. Address 2 is minutes, address 3 hours, and address 4 day of week, with bit 6 as frequency test. Address 5 is date, address 6 month and address 7 year. Read data reflects the visible copy in the same cycle.
- R3: Each tick with the oscillator stop bit at 0 advances the seconds by one BCD count. Carries ripple seconds (59→00), minutes (59→00), hours (23→00), date, month (12→01), year (99→00) and century.
- R4: The date wraps to 01 after 28 or 29 in February, 30 in April, June, September and November, and 31 in all other months. February has 29 days when the BCD year is a multiple of four, including year 00.
- R5: The day of week advances together with the date and wraps from 07 to 01.
- R6: While the read hold is 1, the visible time registers keep the count from before the hold was set, and the counters keep advancing. Once the hold is released, the visible copy shows the live count again in the next cycle.
- R7: Writing control with bit 7 set enters the write hold and loads century bits 5:0 into the visible copy. While either hold is set, writes to addresses 1 to 7 land in the visible copy.
- R8: A control write with bit 7 at 0 while the write hold is set copies every visible register into the counters. A tick in that same cycle is discarded, and the following ticks count on from the loaded values.
- R9: Writes to addresses 1 to 7 while neither hold is set have no effect.
- R10: While seconds bit 7 is 1, ticks do not change the counters. When the bit is 0, the clock runs.
- R11: Bits outside a field's BCD digits (seconds bit 7, minutes bit 7, hours bits 7:6, date bits 7:6, month bits 7:5, day bits 7:3) keep whatever was loaded. They read back unchanged across counting.
- R12: The century counts 00 to 39 and wraps to 00 when the year rolls from 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse, once per second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |

## Verification
Assertions check the relation between the two register sets on every cycle. The visible copy equals the counters whenever no hold is set, and it stays unchanged under a hold with no write. A commit loads the counters from the visible copy. A set stop bit keeps the counters still, and a tick on a running clock always changes them. Month lengths, leap years, day-of-week wrap, century wrap and the preservation of unused bits depend on specific calendar values. Only the bench scenarios show these, by comparing every read against a behavioural calendar model.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_REGS = 8;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int CHAIN_N  = NUM_REGS - 1;

    localparam int IDX_CTRL = 0;
    localparam int IDX_SEC  = 1;
    localparam int IDX_MIN  = 2;
    localparam int IDX_HOUR = 3;
    localparam int IDX_DAY  = 4;
    localparam int IDX_DATE = 5;
    localparam int IDX_MON  = 6;
    localparam int IDX_YEAR = 7;

    typedef logic [NUM_REGS-1:0][BYTE_W-1:0] rtc_regs_t;

    typedef struct packed {
        rtc_regs_t cnt;
        rtc_regs_t vis;
        logic      hold_wr;
        logic      hold_rd;
    } core_state_t;

    // carry order through the counters; day of week rides with the date
    function automatic int chain_idx(input int stage);
        case (stage)
            0:       return IDX_SEC;
            1:       return IDX_MIN;
            2:       return IDX_HOUR;
            3:       return IDX_DATE;
            4:       return IDX_MON;
            5:       return IDX_YEAR;
            default: return IDX_CTRL;
        endcase
    endfunction

    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            IDX_CTRL: return 8'h3F;
            IDX_SEC:  return 8'h7F;
            IDX_MIN:  return 8'h7F;
            IDX_HOUR: return 8'h3F;
            IDX_DAY:  return 8'h07;
            IDX_DATE: return 8'h3F;
            IDX_MON:  return 8'h1F;
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] field_max(input int idx);
        case (idx)
            IDX_CTRL: return 8'h39;
            IDX_SEC:  return 8'h59;
            IDX_MIN:  return 8'h59;
            IDX_HOUR: return 8'h23;
            IDX_DAY:  return 8'h07;
            IDX_DATE: return 8'h31;
            IDX_MON:  return 8'h12;
            default:  return 8'h99;
        endcase
    endfunction

    function automatic logic [7:0] field_min(input int idx);
        if (idx == IDX_DAY || idx == IDX_DATE || idx == IDX_MON)
            return 8'h01;
        return 8'h00;
    endfunction

    // a two-digit BCD number is a multiple of four by its digit pattern
    function automatic logic is_leap(input logic [7:0] yr);
        if (!yr[4])
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] bcd_succ(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic rtc_regs_t reset_regs();
        rtc_regs_t r;
        r           = '0;
        r[IDX_DAY]  = 8'h01;
        r[IDX_DATE] = 8'h01;
        r[IDX_MON]  = 8'h01;
        return r;
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_pkg::*;
(
    input  rtc_regs_t cur,
    output rtc_regs_t nxt
);

    logic       carry;
    logic       wrap;
    logic [7:0] msk;
    logic [7:0] fld;
    logic [7:0] lim;
    logic [7:0] dow;
    int         idx;

    always_comb begin
        nxt   = cur;
        carry = 1'b1;
        wrap  = 1'b0;
        msk   = '0;
        fld   = '0;
        lim   = '0;
        dow   = '0;
        idx   = 0;
        for (int s = 0; s < CHAIN_N; s++) begin
            idx = chain_idx(s);
            msk = field_mask(idx);
            fld = cur[idx] & msk;
            if (idx == IDX_DATE)
                lim = month_len(cur[IDX_MON] & field_mask(IDX_MON), cur[IDX_YEAR]);
            else
                lim = field_max(idx);
            if (carry) begin
                if (idx == IDX_DATE) begin
                    dow = cur[IDX_DAY] & field_mask(IDX_DAY);
                    dow = (dow >= field_max(IDX_DAY)) ? field_min(IDX_DAY) : bcd_succ(dow);
                    nxt[IDX_DAY] = (cur[IDX_DAY] & ~field_mask(IDX_DAY))
                                 | (dow & field_mask(IDX_DAY));
                end
                wrap     = (fld >= lim);
                fld      = wrap ? field_min(idx) : bcd_succ(fld);
                nxt[idx] = (cur[idx] & ~msk) | (fld & msk);
                carry    = wrap;
            end
        end
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(IDX_CTRL);

    core_state_t st_q, st_d;
    rtc_regs_t   stepped;
    logic        ctrl_wr;
    logic        commit;
    logic        frozen_d;

    rtc_cal_step u_step (
        .cur (st_q.cnt),
        .nxt (stepped)
    );

    always_comb begin
        st_d    = st_q;
        ctrl_wr = bus_we && (bus_addr == CTRL_ADDR);
        commit  = ctrl_wr && st_q.hold_wr && !bus_wdata[7];

        if (ctrl_wr) begin
            st_d.hold_wr = bus_wdata[7];
            st_d.hold_rd = bus_wdata[6];
        end

        if (commit)
            st_d.cnt = st_q.vis;
        else if (tick_1s && !st_q.cnt[IDX_SEC][7])
            st_d.cnt = stepped;

        frozen_d = st_d.hold_wr || st_d.hold_rd;
        if (frozen_d) begin
            if (bus_we) begin
                if (bus_addr != CTRL_ADDR)
                    st_d.vis[bus_addr] = bus_wdata;
                else if (bus_wdata[7])
                    st_d.vis[IDX_CTRL] = {2'b00, bus_wdata[5:0]};
            end
        end else begin
            st_d.vis = st_d.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt     <= reset_regs();
            st_q.vis     <= reset_regs();
            st_q.hold_wr <= 1'b0;
            st_q.hold_rd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (bus_addr == CTRL_ADDR)
            bus_rdata = {st_q.hold_wr, st_q.hold_rd, st_q.vis[IDX_CTRL][5:0]};
        else
            bus_rdata = st_q.vis[bus_addr];
    end

    // R6
    live_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.hold_wr || st_q.hold_rd) |-> (st_q.vis == st_q.cnt));

    // R6
    frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold_wr || st_q.hold_rd) && !bus_we |=> $stable(st_q.vis));

    // R8
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && (bus_addr == CTRL_ADDR) && st_q.hold_wr && !bus_wdata[7]
        |=> (st_q.cnt == $past(st_q.vis)));

    // R10
    osc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt[IDX_SEC][7] && !bus_we |=> $stable(st_q.cnt));

    // R3
    tick_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1s && !st_q.cnt[IDX_SEC][7] && !bus_we |=> (st_q.cnt != $past(st_q.cnt)));

endmodule

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/1ps
module test_bcd_rtc_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1s = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic [7:0] last_rd;

    // behavioural model: counters, visible copy, hold bits
    logic [7:0] mc [8];
    logic [7:0] mv [8];
    logic       mwr, mrd;

    always #2.5 clk = ~clk;

    bcd_rtc_core i_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int i);
        logic [7:0] r;
        r[7:4] = 4'(i / 10);
        r[3:0] = 4'(i % 10);
        return r;
    endfunction

    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic put(input int idx, input logic [7:0] m, input int val);
        mc[idx] = (mc[idx] & ~m) | (i2b(val) & m);
    endtask

    task automatic advance();
        int v;
        if (mc[1][7]) return;
        v = b2i(mc[1] & 8'h7F) + 1; put(1, 8'h7F, v % 60); if (v < 60) return;
        v = b2i(mc[2] & 8'h7F) + 1; put(2, 8'h7F, v % 60); if (v < 60) return;
        v = b2i(mc[3] & 8'h3F) + 1; put(3, 8'h3F, v % 24); if (v < 24) return;
        v = b2i(mc[4] & 8'h07); put(4, 8'h07, (v >= 7) ? 1 : v + 1);
        v = b2i(mc[5] & 8'h3F) + 1;
        if (v <= days_in(b2i(mc[6] & 8'h1F), b2i(mc[7]))) begin put(5, 8'h3F, v); return; end
        put(5, 8'h3F, 1);
        v = b2i(mc[6] & 8'h1F) + 1; put(6, 8'h1F, (v > 12) ? 1 : v); if (v <= 12) return;
        v = b2i(mc[7]) + 1; put(7, 8'hFF, v % 100); if (v < 100) return;
        v = b2i(mc[0] & 8'h3F) + 1; put(0, 8'h3F, v % 40);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            mc[i] = (i == 4 || i == 5 || i == 6) ? 8'h01 : 8'h00;
            mv[i] = mc[i];
        end
        mwr = 1'b0; mrd = 1'b0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a, input logic [7:0] wd, input logic tk);
        logic nwr, nrd;
        nwr = mwr; nrd = mrd;
        if (we && a == 3'd0) begin nwr = wd[7]; nrd = wd[6]; end
        if (we && a == 3'd0 && mwr && !wd[7]) begin
            for (int i = 0; i < 8; i++) mc[i] = mv[i];
        end else if (tk) begin
            advance();
        end
        if (nwr || nrd) begin
            if (we && a != 3'd0) mv[a] = wd;
            else if (we && wd[7]) mv[0] = {2'b00, wd[5:0]};
        end else begin
            for (int i = 0; i < 8; i++) mv[i] = mc[i];
        end
        mwr = nwr; mrd = nrd;
    endtask

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        if (a == 3'd0) return {mwr, mrd, mv[0][5:0]};
        return mv[a];
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    // one cycle, entered and left at a falling edge; compares against the model
    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] wd, input logic tk);
        bus_we = we; bus_addr = a; bus_wdata = wd; tick_1s = tk;
        #1;
        last_rd = bus_rdata;
        chk({cur_req, " model"}, bus_rdata, model_rd(a));
        @(posedge clk);
        model_step(we, a, wd, tk);
        @(negedge clk);
        bus_we = 1'b0; tick_1s = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        step(1'b0, a, 8'h00, 1'b0);
        chk(tag, last_rd, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd1, 8'h00, 1'b1);
    endtask

    task automatic load_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                             input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                             input logic [7:0] y, input logic [7:0] c);
        step(1'b1, 3'd0, 8'h80 | c, 1'b0);
        step(1'b1, 3'd1, s, 1'b0);
        step(1'b1, 3'd2, mi, 1'b0);
        step(1'b1, 3'd3, h, 1'b0);
        step(1'b1, 3'd4, dw, 1'b0);
        step(1'b1, 3'd5, dt, 1'b0);
        step(1'b1, 3'd6, mo, 1'b0);
        step(1'b1, 3'd7, y, 1'b0);
        step(1'b1, 3'd0, 8'h00, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        rd_chk(3'd0, 8'h00, "R1 control");
        rd_chk(3'd1, 8'h00, "R1 seconds");
        rd_chk(3'd3, 8'h00, "R1 hours");
        rd_chk(3'd4, 8'h01, "R1 day, FT bit 0");
        rd_chk(3'd5, 8'h01, "R1 date");
        rd_chk(3'd6, 8'h01, "R1 month");
        rd_chk(3'd7, 8'h00, "R1 year");

        cur_req = "R3";
        ticks(5);
        rd_chk(3'd1, 8'h05, "R3 five ticks");

        cur_req = "R12";
        load_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h39);
        rd_chk(3'd0, 8'h39, "R8 century loaded");
        rd_chk(3'd1, 8'h58, "R8 seconds loaded");
        ticks(1);
        rd_chk(3'd1, 8'h59, "R3 59");
        ticks(1);
        rd_chk(3'd1, 8'h00, "R3 sec wrap");
        rd_chk(3'd2, 8'h00, "R3 min wrap");
        rd_chk(3'd3, 8'h00, "R3 hour wrap");
        rd_chk(3'd4, 8'h01, "R5 day 07->01");
        rd_chk(3'd5, 8'h01, "R4 date 31->01");
        rd_chk(3'd6, 8'h01, "R3 month wrap");
        rd_chk(3'd7, 8'h00, "R3 year wrap");
        rd_chk(3'd0, 8'h00, "R12 century 39->00");

        cur_req = "R4";
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20);
        ticks(1);
        rd_chk(3'd5, 8'h29, "R4 leap Feb 29");
        rd_chk(3'd4, 8'h04, "R5 day advance");
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
        ticks(1);
        rd_chk(3'd5, 8'h01, "R4 common Feb end");
        rd_chk(3'd6, 8'h03, "R4 to March");
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h00, 8'h21);
        ticks(1);
        rd_chk(3'd6, 8'h03, "R4 year 00 leap");
        load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h10, 8'h20);
        ticks(1);
        rd_chk(3'd5, 8'h01, "R4 April 30 wrap");
        rd_chk(3'd6, 8'h05, "R4 to May");

        cur_req = "R6";
        load_time(8'h10, 8'h20, 8'h12, 8'h02, 8'h15, 8'h06, 8'h21, 8'h20);
        step(1'b1, 3'd0, 8'h40, 1'b0);
        ticks(3);
        rd_chk(3'd1, 8'h10, "R6 frozen seconds");
        rd_chk(3'd0, 8'h60, "R2 read hold readback");
        step(1'b1, 3'd0, 8'h00, 1'b0);
        rd_chk(3'd1, 8'h13, "R6 live after release");

        cur_req = "R10";
        load_time(8'hC5, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h00);
        ticks(3);
        rd_chk(3'd1, 8'hC5, "R10 stopped");
        load_time(8'h45, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h00);
        ticks(1);
        rd_chk(3'd1, 8'h46, "R10 running");

        cur_req = "R11";
        load_time(8'h59, 8'hD9, 8'hC5, 8'h41, 8'h10, 8'hE3, 8'h05, 8'h00);
        ticks(1);
        rd_chk(3'd2, 8'h80, "R11 minute bit 7 kept");
        rd_chk(3'd3, 8'hC6, "R11 hour bits kept");
        rd_chk(3'd4, 8'h41, "R11 day FT bit kept");
        rd_chk(3'd6, 8'hE3, "R11 month bits kept");

        cur_req = "R9";
        step(1'b1, 3'd2, 8'h33, 1'b0);
        rd_chk(3'd2, 8'h80, "R9 unheld write ignored");

        cur_req = "R8";
        step(1'b1, 3'd0, 8'h80, 1'b0);
        step(1'b1, 3'd1, 8'h30, 1'b0);
        rd_chk(3'd1, 8'h30, "R7 write lands in copy");
        rd_chk(3'd0, 8'h80, "R2 write hold readback");
        step(1'b1, 3'd0, 8'h00, 1'b1);
        rd_chk(3'd1, 8'h30, "R8 tick in commit dropped");
        ticks(1);
        rd_chk(3'd1, 8'h31, "R8 counts from loaded");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule